// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block divides a single input clock by an integer that software sets through a control register. The register holds a divisor code in a bit field whose position is a build parameter. A build-time choice picks how the code becomes a divisor:
- code plus one;
- the code taken directly;
- two raised to the code;
- a lookup table in which a zero entry marks the code as illegal.

A code that does not decode to a legal divisor is refused. The running divisor and the stored code stay as they were, and a sticky error flag rises until the register is read.

A new divisor never cuts a period short. It waits in a pending slot and replaces the running divisor only when the current output period completes, so the output has no runt pulses. A build option adds a latch bit: with it, an accepted code is only staged, and it moves into the pending slot on a write that has the latch bit set. An autoidle request output follows a stored enable bit, and a parameter can invert its polarity. The block has one clock input and never gates its output.

Top module: `prog_clkdiv`

## Requirements
- R1: In code-plus-one mode, the divisor is the field value plus one (code 0 gives 1, code 3 gives 4, code 15 gives 16).
- R2: In direct mode, the divisor equals the field value (code 5 gives 5), and code 0 is refused.
- R3: In power-of-two mode, the divisor is 2 to the power of the code (code 0 gives 1, code 2 gives 4, code 4 gives 16).
- R4: In table mode, the code indexes the DIV_TABLE parameter. An entry of zero makes that code illegal. With the default table, code 0 gives 4, code 1 gives 8, code 2 is illegal, code 3 gives 16, code 7 gives 3 and code 10 is illegal.
- R5: In every mode except table mode, a decoded divisor below MIN_DIV or above MAX_DIV is refused. This includes power-of-two codes whose result does not fit in DIV_W bits. With the defaults (1 and 16), power-of-two codes 5 and 9 are refused.
- R6: A refused write changes neither the running divisor nor the code that reads back, and it sets err_flag. err_flag stays set until a read clears it.
- R7: The read word carries err_flag at bit ERR_BIT (default 31). Bit FIELD_LSB holds the LSB of the last accepted code, and bit IDLE_BIT (default 16) holds the stored autoidle bit. A reg_rd strobe clears err_flag in the next cycle. A refused write in the same cycle wins over the clear.
- R8: With LATCH_EN set, an accepted code is only staged. A write with bit LATCH_BIT (default 17) set moves the divisor into the pending slot: the divisor from that same write if its code is legal, otherwise the last staged divisor.
- R9: idle_req equals the stored autoidle bit XOR IDLE_INV. The bit is updated by every write.
- R10: For a divisor N above 1, each output period lasts N input cycles, and the output is high for the first floor(N/2) of them. A new divisor takes effect only at a period boundary.
- R11: A running divisor of 1 passes clk_in straight to clk_out.
- R12: After reset, err_flag is 0 and the read word is 0. idle_req equals IDLE_INV. The running divisor is RST_DIV (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Parent clock, also clocks the register logic |
| rst_n | input | 1 | Active-low reset, synchronous to clk_in |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe; clears err_flag |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current register image |
| clk_out | output | 1 | Divided clock |
| err_flag | output | 1 | Sticky flag for a refused divisor code |
| idle_req | output | 1 | Autoidle request, polarity set by IDLE_INV |

## Verification
Every internal fault shows up in the shape of clk_out. A wrong period counter or running divisor changes the measured high time or period within one output period, at most 16 input cycles with the defaults. A pending divisor applied too early corrupts the period in which the write landed. A decode fault shows up in two places: err_flag one cycle after the write, and the read-back field. A wrong staged value in latch mode only appears once a latch write promotes it, so the bench commits a staged divisor through a latch write that carries an illegal code.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // How the register field is turned into a divisor
  typedef enum logic [1:0] {
    DEC_MINUS1 = 2'd0,  // divisor = code + 1
    DEC_DIRECT = 2'd1,  // divisor = code, zero illegal
    DEC_POW2   = 2'd2,  // divisor = 2**code
    DEC_TABLE  = 2'd3   // divisor = table[code], zero entry illegal
  } dec_mode_e;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter clkdiv_pkg::dec_mode_e DECODE = clkdiv_pkg::DEC_MINUS1,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned MIN_DIV = 1,
  parameter int unsigned MAX_DIV = 16,
  parameter logic [2**FIELD_W-1:0][DIV_W-1:0] DIV_TABLE = '0
) (
  input  logic [FIELD_W-1:0] code,
  output logic [DIV_W-1:0]   div,
  output logic               ok
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] MAX_V = DIV_W'(MAX_DIV);
  localparam bit USE_RANGE = (DECODE != clkdiv_pkg::DEC_TABLE);

  logic [DIV_W-1:0] raw;
  logic             legal;
  logic             in_rng;

  generate
    if (DECODE == clkdiv_pkg::DEC_MINUS1) begin : g_minus1
      always_comb begin
        raw   = DIV_W'(code) + DIV_W'(1);
        legal = 1'b1;
      end
    end else if (DECODE == clkdiv_pkg::DEC_DIRECT) begin : g_direct
      always_comb begin
        raw   = DIV_W'(code);
        legal = (code != '0);
      end
    end else if (DECODE == clkdiv_pkg::DEC_POW2) begin : g_pow2
      always_comb begin
        legal = (int'(code) < int'(DIV_W));
        raw   = legal ? (DIV_W'(1) << code) : '0;
      end
    end else begin : g_table
      always_comb begin
        raw   = DIV_TABLE[code];
        legal = (raw != '0);
      end
    end
  endgenerate

  assign in_rng = (raw >= MIN_V) && (raw <= MAX_V);
  assign div    = raw;
  assign ok     = legal && (!USE_RANGE || in_rng);

endmodule

// File: rtl/clkdiv_ctrl_regs.sv
module clkdiv_ctrl_regs #(
  parameter int unsigned REG_W     = 32,
  parameter int unsigned FIELD_LSB = 0,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned IDLE_BIT  = 16,
  parameter int unsigned LATCH_BIT = 17,
  parameter int unsigned ERR_BIT   = 31,
  parameter bit          LATCH_EN  = 1'b0,
  parameter int unsigned RST_DIV   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [REG_W-1:0]   wdata,
  input  logic [FIELD_W-1:0] code,
  input  logic [DIV_W-1:0]   dec_div,
  input  logic               dec_ok,
  output logic [REG_W-1:0]   rdata,
  output logic [FIELD_W-1:0] field_q,
  output logic [DIV_W-1:0]   pend_div,
  output logic               err_q,
  output logic               idle_q
);

  localparam logic [DIV_W-1:0] RST_V = DIV_W'(RST_DIV);

  logic accept;
  logic refuse;
  // Write-data bits outside the decoded fields carry no meaning here
  logic spare_bits;

  assign accept     = wr && dec_ok;
  assign refuse     = wr && !dec_ok;
  assign spare_bits = &{1'b0, wdata};

  // Accepted code, as seen on read-back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (accept) begin
      field_q <= code;
    end
  end

  // Sticky error: a refusal wins over a read clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (refuse) begin
      err_q <= 1'b1;
    end else if (rd) begin
      err_q <= 1'b0;
    end
  end

  // Autoidle enable follows every write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
    end else if (wr) begin
      idle_q <= wdata[IDLE_BIT];
    end
  end

  generate
    if (LATCH_EN) begin : g_latched
      logic [DIV_W-1:0] stage_div;
      logic             commit;
      assign commit = wr && wdata[LATCH_BIT];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_div <= RST_V;
        end else if (accept) begin
          stage_div <= dec_div;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_div <= RST_V;
        end else if (commit) begin
          pend_div <= dec_ok ? dec_div : stage_div;
        end
      end
    end else begin : g_direct_apply
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_div <= RST_V;
        end else if (accept) begin
          pend_div <= dec_div;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    rdata[FIELD_LSB +: FIELD_W] = field_q;
    rdata[IDLE_BIT]             = idle_q;
    rdata[ERR_BIT]              = err_q | spare_bits;
  end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] pend_div,
  output logic [DIV_W-1:0] div_act,
  output logic [DIV_W-1:0] cnt_q,
  output logic             phase_q,
  output logic             clk_out
);

  localparam logic [DIV_W-1:0] RST_V   = DIV_W'(RST_DIV);
  localparam bit               RST_PHS = (RST_DIV >= 2);

  logic             wrap;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] half_nxt;
  logic             pass;

  // Period ends on the last count of the running divisor
  assign wrap     = (cnt_q == div_act - DIV_W'(1));
  assign cnt_nxt  = wrap ? '0 : cnt_q + DIV_W'(1);
  assign div_nxt  = wrap ? pend_div : div_act;
  assign half_nxt = div_nxt >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_act <= RST_V;
      phase_q <= RST_PHS;
    end else begin
      cnt_q   <= cnt_nxt;
      div_act <= div_nxt;
      phase_q <= (cnt_nxt < half_nxt);
    end
  end

  assign pass    = (div_act == DIV_W'(1));
  assign clk_out = pass ? clk : phase_q;

endmodule

// File: rtl/prog_clkdiv.sv
module prog_clkdiv #(
  parameter clkdiv_pkg::dec_mode_e DECODE = clkdiv_pkg::DEC_MINUS1,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned FIELD_LSB = 0,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 16,
  parameter logic [2**FIELD_W-1:0][DIV_W-1:0] DIV_TABLE =
    128'h00000000_00000006_03000201_10000804,
  parameter int unsigned IDLE_BIT  = 16,
  parameter bit          IDLE_INV  = 1'b0,
  parameter int unsigned LATCH_BIT = 17,
  parameter bit          LATCH_EN  = 1'b0,
  parameter int unsigned ERR_BIT   = 31,
  parameter int unsigned RST_DIV   = 1
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_out,
  output logic             err_flag,
  output logic             idle_req
);

  logic [FIELD_W-1:0] code;
  logic [DIV_W-1:0]   dec_div;
  logic               code_ok;
  logic [FIELD_W-1:0] field_q;
  logic [DIV_W-1:0]   pend_div;
  logic               idle_q;
  logic [DIV_W-1:0]   div_act;
  logic [DIV_W-1:0]   cnt_q;
  logic               phase_q;

  assign code = reg_wdata[FIELD_LSB +: FIELD_W];

  clkdiv_decode #(
    .DECODE   (DECODE),
    .FIELD_W  (FIELD_W),
    .DIV_W    (DIV_W),
    .MIN_DIV  (MIN_DIV),
    .MAX_DIV  (MAX_DIV),
    .DIV_TABLE(DIV_TABLE)
  ) u_decode (
    .code(code),
    .div (dec_div),
    .ok  (code_ok)
  );

  clkdiv_ctrl_regs #(
    .REG_W    (REG_W),
    .FIELD_LSB(FIELD_LSB),
    .FIELD_W  (FIELD_W),
    .DIV_W    (DIV_W),
    .IDLE_BIT (IDLE_BIT),
    .LATCH_BIT(LATCH_BIT),
    .ERR_BIT  (ERR_BIT),
    .LATCH_EN (LATCH_EN),
    .RST_DIV  (RST_DIV)
  ) u_regs (
    .clk     (clk_in),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .wdata   (reg_wdata),
    .code    (code),
    .dec_div (dec_div),
    .dec_ok  (code_ok),
    .rdata   (reg_rdata),
    .field_q (field_q),
    .pend_div(pend_div),
    .err_q   (err_flag),
    .idle_q  (idle_q)
  );

  clkdiv_core #(
    .DIV_W  (DIV_W),
    .RST_DIV(RST_DIV)
  ) u_core (
    .clk     (clk_in),
    .rst_n   (rst_n),
    .pend_div(pend_div),
    .div_act (div_act),
    .cnt_q   (cnt_q),
    .phase_q (phase_q),
    .clk_out (clk_out)
  );

  assign idle_req = idle_q ^ IDLE_INV;

endmodule

// File: rtl/prog_clkdiv_chk.sv
module prog_clkdiv_chk #(
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned DIV_W    = 8,
  parameter bit          LATCH_EN = 1'b0,
  parameter bit          IDLE_INV = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr,
  input logic               rd,
  input logic               wr_idle,
  input logic               wr_latch,
  input logic               code_ok,
  input logic               err,
  input logic [FIELD_W-1:0] field,
  input logic [DIV_W-1:0]   pend,
  input logic [DIV_W-1:0]   div_act,
  input logic [DIV_W-1:0]   cnt,
  input logic               phase,
  input logic               idle_req
);

  AST_REFUSE_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !code_ok) |=> err); // R6

  AST_REFUSE_KEEPS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !code_ok) |=> $stable(field)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !rd) |=> err); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !(wr && !code_ok)) |=> !err); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCH_EN && wr && !wr_latch) |=> $stable(pend)); // R8

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (idle_req == ($past(wr_idle) ^ IDLE_INV))); // R9

  AST_NO_MIDPERIOD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != div_act - DIV_W'(1)) |=> $stable(div_act)); // R10

  AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase) |-> (cnt == '0)); // R10

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    div_act != '0); // R4

endmodule

bind prog_clkdiv prog_clkdiv_chk #(
  .FIELD_W (FIELD_W),
  .DIV_W   (DIV_W),
  .LATCH_EN(LATCH_EN),
  .IDLE_INV(IDLE_INV)
) u_chk (
  .clk     (clk_in),
  .rst_n   (rst_n),
  .wr      (reg_wr),
  .rd      (reg_rd),
  .wr_idle (reg_wdata[IDLE_BIT]),
  .wr_latch(reg_wdata[LATCH_BIT]),
  .code_ok (code_ok),
  .err     (err_flag),
  .field   (field_q),
  .pend    (pend_div),
  .div_act (div_act),
  .cnt     (cnt_q),
  .phase   (phase_q),
  .idle_req(idle_req)
);

// File: tb/test_prog_clkdiv.sv
`timescale 1ns/1ps
module test_prog_clkdiv;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr  [4];
  logic        rd  [4];
  logic [31:0] wd  [4];
  logic [31:0] rdt [4];
  logic        co  [4];
  logic        er  [4];
  logic        idl [4];

  int checks = 0;
  int failures = 0;
  int cur_div [4];
  int cur_code [4];

  prog_clkdiv #(.DECODE(clkdiv_pkg::DEC_MINUS1)) i_prog_clkdiv (
    .clk_in(clk), .rst_n(rst_n), .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_wdata(wd[0]),
    .reg_rdata(rdt[0]), .clk_out(co[0]), .err_flag(er[0]), .idle_req(idl[0]));

  prog_clkdiv #(.DECODE(clkdiv_pkg::DEC_DIRECT), .LATCH_EN(1'b1), .IDLE_INV(1'b1)) i_prog_clkdiv_direct (
    .clk_in(clk), .rst_n(rst_n), .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_wdata(wd[1]),
    .reg_rdata(rdt[1]), .clk_out(co[1]), .err_flag(er[1]), .idle_req(idl[1]));

  prog_clkdiv #(.DECODE(clkdiv_pkg::DEC_POW2), .FIELD_LSB(8)) i_prog_clkdiv_pow2 (
    .clk_in(clk), .rst_n(rst_n), .reg_wr(wr[2]), .reg_rd(rd[2]), .reg_wdata(wd[2]),
    .reg_rdata(rdt[2]), .clk_out(co[2]), .err_flag(er[2]), .idle_req(idl[2]));

  prog_clkdiv #(.DECODE(clkdiv_pkg::DEC_TABLE)) i_prog_clkdiv_table (
    .clk_in(clk), .rst_n(rst_n), .reg_wr(wr[3]), .reg_rd(rd[3]), .reg_wdata(wd[3]),
    .reg_rdata(rdt[3]), .clk_out(co[3]), .err_flag(er[3]), .idle_req(idl[3]));

  typedef struct packed {
    logic [1:0] m;
    logic [3:0] code;
    logic       ok;
    logic [7:0] div;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd0,  1'b1, 8'd1,  4'd1}, '{2'd0, 4'd3,  1'b1, 8'd4,  4'd1},
    '{2'd0, 4'd6,  1'b1, 8'd7,  4'd1}, '{2'd0, 4'd15, 1'b1, 8'd16, 4'd1},
    '{2'd1, 4'd1,  1'b1, 8'd1,  4'd2}, '{2'd1, 4'd5,  1'b1, 8'd5,  4'd2},
    '{2'd1, 4'd0,  1'b0, 8'd0,  4'd2}, '{2'd1, 4'd9,  1'b1, 8'd9,  4'd2},
    '{2'd2, 4'd0,  1'b1, 8'd1,  4'd3}, '{2'd2, 4'd2,  1'b1, 8'd4,  4'd3},
    '{2'd2, 4'd4,  1'b1, 8'd16, 4'd3}, '{2'd2, 4'd5,  1'b0, 8'd0,  4'd5},
    '{2'd2, 4'd9,  1'b0, 8'd0,  4'd5}, '{2'd3, 4'd0,  1'b1, 8'd4,  4'd4},
    '{2'd3, 4'd1,  1'b1, 8'd8,  4'd4}, '{2'd3, 4'd2,  1'b0, 8'd0,  4'd4},
    '{2'd3, 4'd3,  1'b1, 8'd16, 4'd4}, '{2'd3, 4'd7,  1'b1, 8'd3,  4'd4},
    '{2'd3, 4'd10, 1'b0, 8'd0,  4'd4}
  };

  function automatic string rtag(int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int lsb_of(int m);
    return (m == 2) ? 8 : 0;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(input int m, output logic c);
    @(negedge clk);
    #1;
    c = co[m];
  endtask

  task automatic wr_reg(input int m, input int code, input bit latch, input bit idle);
    @(negedge clk);
    wr[m] = 1'b1;
    wd[m] = (32'(code) << lsb_of(m)) | (32'(latch) << 17) | (32'(idle) << 16);
    @(negedge clk);
    #1;
    wr[m] = 1'b0;
  endtask

  task automatic rd_reg(input int m, output logic [31:0] v);
    @(negedge clk);
    rd[m] = 1'b1;
    #1;
    v = rdt[m];
    @(negedge clk);
    #1;
    rd[m] = 1'b0;
  endtask

  task automatic wait_rise(input int m);
    logic p;
    logic c;
    smp(m, p);
    for (int i = 0; i < 600; i++) begin
      smp(m, c);
      if (c && !p) break;
      p = c;
    end
  endtask

  // Starts on a sample that just rose; counts until the next rise
  task automatic count_period(input int m, output int t, output int h);
    logic p;
    logic c;
    t = 1; h = 1; p = 1'b1;
    for (int i = 0; i < 600; i++) begin
      smp(m, c);
      if (c && !p) break;
      t++;
      if (c) h++;
      p = c;
    end
  endtask

  task automatic measure(input int m, input int n, input string req);
    int t;
    int h;
    if (n == 1) begin
      repeat (40) @(negedge clk);
      @(posedge clk); #2;
      chk(co[m] == 1'b1, req, int'(co[m]), 1);
      @(negedge clk); #2;
      chk(co[m] == 1'b0, req, int'(co[m]), 0);
    end else begin
      wait_rise(m);
      wait_rise(m);
      count_period(m, t, h);
      chk(t == n, req, t, n);
      chk(h == n / 2, req, h, n / 2);
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t;
    int h;
    for (int m = 0; m < 4; m++) begin
      wr[m] = 1'b0; rd[m] = 1'b0; wd[m] = '0;
      cur_div[m] = 1; cur_code[m] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R12: reset state of every variant
    for (int m = 0; m < 4; m++) begin
      chk(er[m] == 1'b0, "R12", int'(er[m]), 0);
      chk(rdt[m] == 32'd0, "R12", int'(rdt[m]), 0);
      chk(idl[m] == (m == 1), "R12", int'(idl[m]), int'(m == 1));
    end
    // R11: divisor 1 after reset passes the input clock through
    measure(0, 1, "R11");

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      int m;
      m = int'(VEC[i].m);
      wr_reg(m, int'(VEC[i].code), 1'b1, 1'b0);
      if (VEC[i].ok) begin
        cur_div[m] = int'(VEC[i].div);
        cur_code[m] = int'(VEC[i].code);
        chk(er[m] == 1'b0, rtag(int'(VEC[i].req)), int'(er[m]), 0);
        measure(m, cur_div[m], rtag(int'(VEC[i].req)));
      end else begin
        chk(er[m] == 1'b1, rtag(int'(VEC[i].req)), int'(er[m]), 1);
        chk(((rdt[m] >> lsb_of(m)) & 32'hF) == 32'(cur_code[m]), "R6",
            int'((rdt[m] >> lsb_of(m)) & 32'hF), cur_code[m]);
        rd_reg(m, v);
        chk(v[31] == 1'b1, "R7", int'(v[31]), 1);
        chk(er[m] == 1'b0, "R7", int'(er[m]), 0);
        measure(m, cur_div[m], "R6");
      end
    end

    // R8: staged code waits for the latch bit
    wr_reg(1, 3, 1'b0, 1'b0);
    chk(((rdt[1]) & 32'hF) == 32'd3, "R8", int'(rdt[1] & 32'hF), 3);
    measure(1, 9, "R8");
    wr_reg(1, 7, 1'b0, 1'b0);
    measure(1, 9, "R8");
    wr_reg(1, 0, 1'b1, 1'b0);  // illegal code with latch: promote staged 7
    chk(er[1] == 1'b1, "R8", int'(er[1]), 1);
    measure(1, 7, "R8");
    rd_reg(1, v);

    // R9: autoidle polarity
    wr_reg(1, 7, 1'b0, 1'b1);
    chk(idl[1] == 1'b0, "R9", int'(idl[1]), 0);
    chk(rdt[1][16] == 1'b1, "R9", int'(rdt[1][16]), 1);
    wr_reg(0, 15, 1'b0, 1'b1);
    chk(idl[0] == 1'b1, "R9", int'(idl[0]), 1);

    // R7: refusal in the same cycle as a read leaves the flag set
    @(negedge clk);
    wr[3] = 1'b1; rd[3] = 1'b1; wd[3] = 32'd2;
    @(negedge clk); #1;
    wr[3] = 1'b0; rd[3] = 1'b0;
    chk(er[3] == 1'b1, "R7", int'(er[3]), 1);
    rd_reg(3, v);
    chk(er[3] == 1'b0, "R7", int'(er[3]), 0);

    // R10: change requested mid-period waits for the boundary (16 then 2)
    wait_rise(0);
    wr[0] = 1'b1;
    wd[0] = 32'd1 | (32'd1 << 16);
    fork
      begin @(negedge clk); wr[0] = 1'b0; end
    join_none
    count_period(0, t, h);
    chk(t == 16, "R10", t, 16);
    chk(h == 8, "R10", h, 8);
    count_period(0, t, h);
    chk(t == 2, "R10", t, 2);
    chk(h == 1, "R10", h, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule